// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers single-cycle event pulses from a reader's transmit, receive, FIFO and error-checking logic. It latches them into an 8-bit status word and drives one active-high interrupt line to the host. Software masks the FIFO and error sources through an enable register. A read of the status word returns every pending flag and clears them all in one step.

A no-response timer runs alongside the flags. When transmission finishes, it loads a programmable wait value and counts it down in units of a fixed prescaled clock. If no receive start-of-frame arrives before the count runs out, a timeout flag is raised. A start-of-frame cancels the count.

The host reaches three registers through a plain strobe port: status at address 0x0C (read-only, cleared on read), enable at 0x0D and wait time at 0x0E. Read data is registered and appears the cycle after the read strobe.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, the status word reads 0x00, `irq` is 0, the enable register reads 0x3C (all four maskable sources enabled) and the wait register reads 0.
- R2: A `tx_start` pulse sets status bit 7 in the next cycle, but on its own it leaves `irq` low.
- R3: A `tx_done` pulse sets status bit 7 and raises `irq` in the next cycle.
- R4: A `rx_sof` pulse sets status bit 6 and raises `irq` in the next cycle, whatever the enable register holds.
- R5: The maskable sources map to status and enable bits as follows: `fifo_evt` to bit 5, `crc_err` to bit 4, `par_err` to bit 3 and `frm_err` to bit 2. While its enable bit is 1, a pulse on a source sets its status bit and raises `irq` in the next cycle.
- R6: While its enable bit is 0, a pulse on a maskable source is ignored: its status bit stays 0 and `irq` stays low. Writes to enable bits 7, 6, 1 and 0 have no effect, and those bits read back 0.
- R7: A read strobe at address 0x0C returns the pending flags on `rd_data` in the next cycle. In that same cycle the flags are cleared and `irq` falls, unless new events arrived.
- R8: An event that arrives in the same cycle as a status read does not appear in that read's data. It stays pending for the next read and keeps `irq` high.
- R9: With wait value W (not 0) and prescale P, status bit 0 is set and `irq` rises exactly W*P cycles after the cycle in which `tx_done` was sampled, provided no `rx_sof` arrives in between.
- R10: A `rx_sof` that arrives before the timer expires cancels it, so status bit 0 is never set for that transmission.
- R11: A wait value of 0 disables the timer, so `tx_done` never leads to a timeout.
- R12: Reads of the enable and wait registers return their contents and do not clear the status. A read at any other address returns 0x00. Status bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Pulse: transmission began |
| tx_done | input | 1 | Pulse: transmission finished, starts the timer |
| rx_sof | input | 1 | Pulse: receive start-of-frame detected |
| fifo_evt | input | 1 | Pulse: FIFO level event |
| crc_err | input | 1 | Pulse: CRC check failed |
| par_err | input | 1 | Pulse: parity check failed |
| frm_err | input | 1 | Pulse: framing or end-of-frame error |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The bench builds the block with a 4-bit wait register and a prescale of 3. With these values every wait setting from 1 to 15 can be swept, and each timeout lands within 45 cycles, so the exact expiry cycle is checked for all of them. The small configuration also makes it cheap to walk all 16 enable patterns against each of the four maskable sources. Cancellation, a zero wait value and collisions between a status read and a new event are covered as well.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W   = 8;
  localparam int B_TXEND  = 7;
  localparam int B_RXSOF  = 6;
  localparam int B_FIFO   = 5;
  localparam int B_CRC    = 4;
  localparam int B_PAR    = 3;
  localparam int B_FRM    = 2;
  localparam int B_NORESP = 0;
  localparam logic [STAT_W-1:0] MASKABLE = 8'h3C;
endpackage

// File: rtl/irq_nrsp_timer.sv
module irq_nrsp_timer #(
  parameter int WAIT_W = 8,
  parameter int PRESC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cancel,
  input  logic [WAIT_W-1:0] wait_val,
  output logic              expire,
  output logic              busy
);
  localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              act_q;
  logic              tick;

  assign tick   = (pre_q == PRE_LAST);
  assign expire = act_q && tick && (cnt_q == WAIT_W'(1)) && !start && !cancel;
  assign busy   = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cancel) begin
      act_q <= 1'b0;
      pre_q <= '0;
    end else if (start) begin
      cnt_q <= wait_val;
      pre_q <= '0;
      act_q <= (wait_val != '0);
    end else if (act_q) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - WAIT_W'(1);
        if (cnt_q == WAIT_W'(1)) act_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              fin_set,
  input  logic              clr,
  output logic [STAT_W-1:0] flags,
  output logic              irq
);
  logic [STAT_W-1:0] flags_q, flags_d;
  logic              fin_q, fin_d, irq_q, irq_d;

  always_comb begin
    flags_d = (clr ? '0 : flags_q) | set_vec;
    fin_d   = (clr ? 1'b0 : fin_q) | fin_set;
    irq_d   = (|flags_d[STAT_W-2:0]) | (flags_d[B_TXEND] & fin_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      fin_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      fin_q   <= fin_d;
      irq_q   <= irq_d;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WAIT_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h0C,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 5'h0D,
  parameter logic [ADDR_W-1:0] WAIT_ADDR = 5'h0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] flags,
  output logic [STAT_W-1:0] rd_data,
  output logic [STAT_W-1:0] mask,
  output logic [WAIT_W-1:0] wait_val,
  output logic              clr
);
  logic [STAT_W-1:0] mask_q, rd_q, rd_mux;
  logic [WAIT_W-1:0] wait_q;

  assign clr = rd_en && (rd_addr == STAT_ADDR);

  always_comb begin
    unique case (rd_addr)
      STAT_ADDR: rd_mux = flags;
      MASK_ADDR: rd_mux = mask_q;
      WAIT_ADDR: rd_mux = STAT_W'(wait_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASKABLE;
      wait_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en && wr_addr == MASK_ADDR) mask_q <= wr_data & MASKABLE;
      if (wr_en && wr_addr == WAIT_ADDR) wait_q <= wr_data[WAIT_W-1:0];
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign rd_data  = rd_q;
  assign mask     = mask_q;
  assign wait_val = wait_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WAIT_W = 8,
  parameter int PRESC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              rx_sof,
  input  logic              fifo_evt,
  input  logic              crc_err,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  logic [STAT_W-1:0] stat_flags, mask_q, set_vec;
  logic [WAIT_W-1:0] wait_q;
  logic              clr, expire, busy;

  always_comb begin
    set_vec           = '0;
    set_vec[B_TXEND]  = tx_start | tx_done;
    set_vec[B_RXSOF]  = rx_sof;
    set_vec[B_FIFO]   = fifo_evt & mask_q[B_FIFO];
    set_vec[B_CRC]    = crc_err  & mask_q[B_CRC];
    set_vec[B_PAR]    = par_err  & mask_q[B_PAR];
    set_vec[B_FRM]    = frm_err  & mask_q[B_FRM];
    set_vec[B_NORESP] = expire;
  end

  irq_regs #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .flags(stat_flags), .rd_data(rd_data),
    .mask(mask_q), .wait_val(wait_q), .clr(clr)
  );

  irq_nrsp_timer #(.WAIT_W(WAIT_W), .PRESC(PRESC)) i_timer (
    .clk(clk), .rst(rst), .start(tx_done), .cancel(rx_sof),
    .wait_val(wait_q), .expire(expire), .busy(busy)
  );

  irq_flags i_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .fin_set(tx_done), .clr(clr),
    .flags(stat_flags), .irq(irq)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_start,
  input logic              tx_done,
  input logic              rx_sof,
  input logic              fifo_evt,
  input logic              crc_err,
  input logic              par_err,
  input logic              frm_err,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        flags,
  input logic [WAIT_W-1:0] wait_val,
  input logic              expire,
  input logic              busy,
  input logic              irq
);
  logic any_evt;
  assign any_evt = tx_start | tx_done | rx_sof | fifo_evt | crc_err | par_err | frm_err | expire;

  // R2
  txstart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !tx_done && !rx_sof && !fifo_evt && !crc_err && !par_err && !frm_err
     && !expire && !irq && flags == 8'h00) |=> (!irq && flags[7]));

  // R4
  rxsof_irq_chk: assert property (@(posedge clk) disable iff (rst)
    rx_sof |=> (flags[6] && irq));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(12) && !any_evt) |=> (!irq && flags == 8'h00));

  // R9
  timeout_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (flags[0] && irq));

  // R11
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !rx_sof && wait_val == '0) |=> !busy);

  // R12
  bit1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !flags[1]);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_start(tx_start), .tx_done(tx_done), .rx_sof(rx_sof),
  .fifo_evt(fifo_evt), .crc_err(crc_err), .par_err(par_err), .frm_err(frm_err),
  .rd_en(rd_en), .rd_addr(rd_addr), .flags(stat_flags), .wait_val(wait_q),
  .expire(expire), .busy(busy), .irq(irq)
);

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  localparam int AW = 5;
  localparam int WW = 4;
  localparam int PS = 3;
  localparam logic [AW-1:0] A_STAT = 5'h0C;
  localparam logic [AW-1:0] A_MASK = 5'h0D;
  localparam logic [AW-1:0] A_WAIT = 5'h0E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_start = 0, tx_done = 0, rx_sof = 0;
  logic fifo_evt = 0, crc_err = 0, par_err = 0, frm_err = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_ctrl_top #(.ADDR_W(AW), .WAIT_W(WW), .PRESC(PS)) i_irq_ctrl_top (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_done(tx_done), .rx_sof(rx_sof),
    .fifo_evt(fifo_evt), .crc_err(crc_err), .par_err(par_err), .frm_err(frm_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    step();
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic pulse_src(input int i);
    case (i)
      0: fifo_evt = 1;
      1: crc_err  = 1;
      2: par_err  = 1;
      default: frm_err = 1;
    endcase
    step();
    fifo_evt = 0; crc_err = 0; par_err = 0; frm_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk); step(); rst = 0; step();

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(A_STAT, d); chk("R1 status", d, 8'h00);
    rd(A_MASK, d); chk("R1 enable", d, 8'h3C);
    rd(A_WAIT, d); chk("R1 wait", d, 8'h00);

    // R2 tx_start sets bit7, no irq
    tx_start = 1; step(); tx_start = 0;
    chk("R2 irq after tx_start", irq, 0);
    step(); chk("R2 irq still low", irq, 0);
    // R3 tx_done raises irq
    tx_done = 1; step(); tx_done = 0;
    chk("R3 irq after tx_done", irq, 1);
    // R7 read returns and clears
    rd(A_STAT, d); chk("R7 status data", d, 8'h80);
    chk("R7 irq cleared", irq, 0);
    rd(A_STAT, d); chk("R7 status empty", d, 8'h00);

    // R4 rx_sof with all sources masked
    wr(A_MASK, 8'h00);
    rx_sof = 1; step(); rx_sof = 0;
    chk("R4 irq", irq, 1);
    // R12 non-status reads keep status
    rd(A_MASK, d); chk("R12 enable read", d, 8'h00);
    chk("R12 irq kept", irq, 1);
    rd(5'h1F, d); chk("R12 unmapped", d, 8'h00);
    rd(A_STAT, d); chk("R4 status", d, 8'h40);

    // R5 R6 sweep of all enable patterns and sources
    for (int m = 0; m < 16; m++) begin
      wr(A_MASK, 8'((m << 2) | 8'hC3));
      rd(A_MASK, d); chk("R6 enable readback", d, m << 2);
      for (int s = 0; s < 4; s++) begin
        int en;
        en = (m >> (3 - s)) & 1;
        pulse_src(s);
        chk(en ? "R5 irq enabled" : "R6 irq masked", irq, en);
        rd(A_STAT, d);
        chk(en ? "R5 status bit" : "R6 status bit", d, en ? (1 << (5 - s)) : 0);
      end
    end
    wr(A_MASK, 8'h3C);

    // R8 event during status read
    fifo_evt = 1; step(); fifo_evt = 0;
    crc_err = 1; rd_en = 1; rd_addr = A_STAT; step(); crc_err = 0; rd_en = 0;
    chk("R8 read data", rd_data, 8'h20);
    chk("R8 irq kept", irq, 1);
    rd(A_STAT, d); chk("R8 kept flag", d, 8'h10);

    // R9 timeout for every wait value
    for (int w = 1; w < 16; w++) begin
      wr(A_WAIT, 8'(w));
      tx_done = 1; step(); tx_done = 0;
      rd(A_STAT, d);
      chk("R9 txend flag", d, 8'h80);
      for (int k = 2; k <= w * PS; k++) begin
        step();
        if (k >= w * PS - 1) chk("R9 irq timing", irq, (k == w * PS) ? 1 : 0);
      end
      rd(A_STAT, d); chk("R9 noresp flag", d, 8'h01);
    end
    rd(A_WAIT, d); chk("R12 wait read", d, 8'h0F);

    // R10 cancel by rx_sof
    wr(A_WAIT, 8'd5);
    tx_done = 1; step(); tx_done = 0;
    rd(A_STAT, d);
    repeat (5) step();
    rx_sof = 1; step(); rx_sof = 0;
    repeat (20) step();
    rd(A_STAT, d); chk("R10 no timeout", d, 8'h40);
    chk("R10 irq", irq, 0);

    // R11 zero wait
    wr(A_WAIT, 8'd0);
    tx_done = 1; step(); tx_done = 0;
    rd(A_STAT, d);
    repeat (60) step();
    chk("R11 irq", irq, 0);
    rd(A_STAT, d); chk("R11 status", d, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule